// File: doc/BRIEF.md
# Second-Order Range-Scaled Bitstream Modulator

This block turns a 16-bit converter code into a one-bit density stream. An external low-pass filter and output stage then average the stream into a loop current. First the code is placed inside one of several output ranges, all measured against a common 0-to-24 unit span. One range has a live-zero floor at 4 units, so code zero does not mean zero output. The scaled level then drives a second-order noise-shaping loop. The loop has two saturating integrators, and its sign decision is fed back as either zero or the full span.

A clear input overrides the code and holds the level at the floor of the selected range for as long as it is high. Range select and clear are sampled on every clock, together with the code. The fraction of ones in the output over a long window equals the scaled level divided by the full span.

Top module: `sd2_mod`

## Requirements
- R1: While `rst_n` is low, the level register and both integrators are zero and `bit_out` is 0. It stays 0 on the first cycle after release.
- R2: On every rising clock edge the level register loads a value derived from `code` (C) and `range_sel`. The full span FS is 24·2^CODE_W. For `range_sel`=2'b00 (4–20) the level is 4·2^CODE_W + 16·C. For 2'b01 (0–20) it is 20·C. For 2'b10 (0–24) it is 24·C.
- R3: While `clear` is high, `code` is ignored and the level loads the range floor: 4·2^CODE_W for 2'b00 and 0 for every other range.
- R4: On each edge, with y the present `bit_out` and f = y·FS, the first integrator becomes sat(i1 + level − f). The second becomes sat(i2 + new i1 − f). `bit_out` is 1 exactly when the second integrator is greater than zero.
- R5: Both integrators are signed INT_W bits wide and clamp at the signed limits instead of wrapping. After a jump from full scale to zero, the loop recovers and produces ones again within 32 cycles of full scale being reapplied.
- R6: Over a window of N cycles at a constant level L, the count of ones is within 4 of N·L/FS.
- R7: For a fixed range, a larger code never gives a smaller ones density.
- R8: `range_sel`=2'b11 behaves as the 0–24 range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code | input | CODE_W | Converter code, unsigned |
| range_sel | input | 2 | Output range: 00 = 4–20, 01 = 0–20, 10/11 = 0–24 |
| clear | input | 1 | Forces the level to the range floor |
| bit_out | output | 1 | One-bit density stream |

## Verification
The bench builds the block with its defaults, CODE_W = 16 and INT_W = 24. With these values the integrator limits are only about five full spans from zero. A sudden fall from full scale to code zero therefore drives the second integrator into its negative clamp within a few cycles, so the saturation path runs in ordinary stimulus. The 16-bit code width keeps every scaled level an exact integer. This lets the per-cycle model and the long-window density checks use exact ratios: half scale in both the live-zero and the 0–24 ranges, one sixth for a cleared live-zero range, and exact zero for a cleared 0–20 range.

// File: rtl/sd2_mod.sv
module sd2_mod #(
  parameter int CODE_W = 16,
  parameter int INT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        range_sel,
  input  logic              clear,
  output logic              bit_out
);

  localparam int LW = CODE_W + 5;
  localparam int SW = INT_W + 2;
  localparam logic [LW-1:0] FULL  = LW'(24) << CODE_W;
  localparam logic [LW-1:0] FLOOR = LW'(4) << CODE_W;
  localparam logic signed [INT_W-1:0] IMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] IMIN = {1'b1, {(INT_W-1){1'b0}}};

  logic [LW-1:0]             lvl_d, lvl_q;
  logic signed [INT_W-1:0]   i1_q, i2_q, i1_n, i2_n;
  logic signed [SW-1:0]      fb, lvl_s, sum1, sum2;

  function automatic logic signed [INT_W-1:0] clamp(input logic signed [SW-1:0] s);
    if (s > SW'(IMAX))      return IMAX;
    else if (s < SW'(IMIN)) return IMIN;
    else                    return s[INT_W-1:0];
  endfunction

  always_comb begin
    if (clear)
      lvl_d = (range_sel == 2'b00) ? FLOOR : '0;
    else begin
      case (range_sel)
        2'b00:   lvl_d = FLOOR + LW'(code) * LW'(16);
        2'b01:   lvl_d = LW'(code) * LW'(20);
        default: lvl_d = LW'(code) * LW'(24);
      endcase
    end
  end

  assign bit_out = !i2_q[INT_W-1] && (i2_q != '0);
  assign fb      = bit_out ? SW'(FULL) : '0;
  assign lvl_s   = SW'({1'b0, lvl_q});
  assign sum1    = SW'(i1_q) + lvl_s - fb;
  assign i1_n    = clamp(sum1);
  assign sum2    = SW'(i2_q) + SW'(i1_n) - fb;
  assign i2_n    = clamp(sum2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      i1_q  <= '0;
      i2_q  <= '0;
    end else begin
      lvl_q <= lvl_d;
      i1_q  <= i1_n;
      i2_q  <= i2_n;
    end
  end

endmodule

// File: rtl/sd2_mod_sva.sv
module sd2_mod_sva #(
  parameter int CODE_W = 16,
  parameter int INT_W  = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clear,
  input logic [1:0]              range_sel,
  input logic                    bit_out,
  input logic [CODE_W+4:0]       lvl_q,
  input logic signed [INT_W-1:0] i1_q
);

  localparam int LW = CODE_W + 5;
  localparam logic [LW-1:0] FULL  = LW'(24) << CODE_W;
  localparam logic [LW-1:0] FLOOR = LW'(4) << CODE_W;
  localparam logic signed [INT_W-1:0] IMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] IMIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic signed [INT_W-1:0] TOP_BAND = IMAX - INT_W'(FULL);
  localparam logic signed [INT_W-1:0] BOT_BAND = IMIN + INT_W'(FULL);

  a_r1_release_low: assert property (@(posedge clk) $rose(rst_n) |-> !bit_out);

  a_r3_clear_floor: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> lvl_q == (($past(range_sel) == 2'b00) ? FLOOR : '0));

  a_r2_live_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && range_sel == 2'b00) |=> lvl_q >= FLOOR);

  a_r5_i1_top_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (i1_q == IMAX) |=> i1_q >= TOP_BAND);

  a_r5_i1_bottom_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (i1_q == IMIN) |=> i1_q <= BOT_BAND);

  a_r4_out_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(bit_out));

endmodule

bind sd2_mod sd2_mod_sva #(.CODE_W(CODE_W), .INT_W(INT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .clear(clear), .range_sel(range_sel),
  .bit_out(bit_out), .lvl_q(lvl_q), .i1_q(i1_q)
);

// File: tb/tb_sd2_mod.sv
`timescale 1ns/1ps
module tb_sd2_mod;
  localparam int CW = 16;
  localparam int IW = 24;
  localparam longint FS   = 24 * (longint'(1) << CW);
  localparam longint LOW  = 4 * (longint'(1) << CW);
  localparam longint IMAX = (longint'(1) << (IW-1)) - 1;
  localparam longint IMIN = -(longint'(1) << (IW-1));

  logic clk = 0;
  logic rst_n = 0;
  logic [CW-1:0] code = '0;
  logic [1:0] range_sel = 2'b00;
  logic clear = 0;
  logic bit_out;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 0;
  longint m_lvl, m_i1, m_i2;

  always #2.5 clk = ~clk;

  sd2_mod #(.CODE_W(CW), .INT_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .code(code), .range_sel(range_sel),
    .clear(clear), .bit_out(bit_out)
  );

  function automatic longint clampv(input longint v);
    if (v > IMAX) return IMAX;
    if (v < IMIN) return IMIN;
    return v;
  endfunction

  function automatic longint level_of(input logic c, input logic [1:0] r, input longint k);
    if (c) return (r == 2'b00) ? LOW : 0;
    case (r)
      2'b00:   return LOW + 16 * k;
      2'b01:   return 20 * k;
      default: return 24 * k;
    endcase
  endfunction

  // behavioural reference (R2, R3, R4, R5)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = 0; m_i1 = 0; m_i2 = 0;
    end else begin
      longint f;
      f = (m_i2 > 0) ? FS : 0;
      m_i1 = clampv(m_i1 + m_lvl - f);
      m_i2 = clampv(m_i2 + m_i1 - f);
      m_lvl = level_of(clear, range_sel, longint'(code));
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (bit_out !== (m_i2 > 0)) begin
        errors++;
        $display("FAIL R4 t=%0t bit_out=%0b expected=%0b", $time, bit_out, (m_i2 > 0));
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [CW-1:0] k, input logic [1:0] r, input logic c);
    @(negedge clk);
    code = k; range_sel = r; clear = c;
  endtask

  task automatic density(input logic [CW-1:0] k, input logic [1:0] r, input logic c,
                         input int n, input longint tol, input string req, output longint ones);
    longint exp_x, diff;
    apply(k, r, c);
    repeat (256) @(negedge clk);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ones += bit_out;
    end
    exp_x = (longint'(n) * level_of(c, r, longint'(k)) + FS / 2) / FS;
    diff = ones - exp_x;
    if (diff < 0) diff = -diff;
    check(diff <= tol, req, ones, exp_x);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    longint c0, c1, c2, tmp;
    int rec;
    repeat (3) @(negedge clk);
    check(bit_out == 1'b0, "R1 reset output", bit_out, 0);
    rst_n = 1;
    @(negedge clk);
    check(bit_out == 1'b0, "R1 first cycle after release", bit_out, 0);
    cmp_en = 1;

    density(16'h8000, 2'b00, 1'b0, 65536, 4, "R6 R2 live-zero half scale", tmp);
    density(16'h8000, 2'b11, 1'b0, 8192, 4, "R8 range 3 as 0-24", tmp);
    density(16'h4000, 2'b01, 1'b0, 16384, 4, "R2 0-20 quarter code", tmp);
    density(16'hFFFF, 2'b00, 1'b1, 16384, 4, "R3 clear live-zero floor", tmp);
    density(16'hFFFF, 2'b01, 1'b1, 2048, 1, "R3 clear 0-20 gives zero", tmp);

    density(16'h1000, 2'b10, 1'b0, 8192, 4, "R7 code 0x1000", c0);
    density(16'h2000, 2'b10, 1'b0, 8192, 4, "R7 code 0x2000", c1);
    density(16'h3000, 2'b10, 1'b0, 8192, 4, "R7 code 0x3000", c2);
    check(c0 <= c1, "R7 monotonic low pair", c0, c1);
    check(c1 <= c2, "R7 monotonic high pair", c1, c2);

    apply(16'hFFFF, 2'b10, 1'b0);
    repeat (200) @(negedge clk);
    apply(16'h0000, 2'b01, 1'b0);
    repeat (64) @(negedge clk);
    check(bit_out == 1'b0, "R5 held low at zero after clamp", bit_out, 0);
    apply(16'hFFFF, 2'b10, 1'b0);
    rec = -1;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (bit_out && rec < 0) rec = i;
    end
    check(rec >= 0, "R5 recovery from clamp", rec, 31);

    repeat (8) @(negedge clk);
    cmp_en = 0;
    @(negedge clk);
    summary();
    $finish;
  end
endmodule